// File: doc/BRIEF.md
# Serial ADC Control-Byte Front End

This block is the digital front end of a serial successive-approximation converter. The host holds chip-select low and clocks bits in on the data input at each rising edge of the serial clock. Leading zeros are skipped. The first logic 1 opens an 8-bit control byte. The block then counts falling serial-clock edges to time an acquisition and conversion phase. It raises a strobe for one serial-clock period just before the result. It then shifts the result word out MSB first and pads the rest of the frame with zeros. The conversion itself is not modelled: the result word is taken from a parallel input at the strobe edge. Three user output bits are loaded from the control byte.

The control byte, first bit received first, is laid out as follows:

| Bit | Meaning |
|-----|---------|
| bit 7 | Start bit. |
| bit 6 | Polarity select. It is captured but has no effect here. |
| bit 5 | Clock-source select. It is captured but has no effect here; the serial clock always steps the frame. |
| bits 4:3 | Mode field. The value 2'b11 selects long acquisition; any other value selects short. |
| bits 2:0 | User output bits. |

A re-arm lets the host abort a frame. The host raises chip-select and lowers it again while a frame runs; a new start bit then restarts the frame at once. All inputs are synchronous to `clk`. The serial clock runs well below `clk`, and each serial-clock level lasts at least two `clk` cycles.

Top module: `sadc_ctrl_if`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `sstrb`, `dout` and `user_out` are all 0.
- R2: Serial-clock edges are acted on only while `cs_n` is low. Ones clocked while `cs_n` is high start nothing.
- R3: While armed, 0 bits have no effect. The first 1 seen on a rising edge is the start bit (control bit 7). The next seven rising edges supply bits 6 down to 0.
- R4: In short mode, `sstrb` rises at the 7th falling edge after the start bit and falls at the 8th. The frame ends at the 24th falling edge.
- R5: `result_i` is sampled at the strobe edge. Its MSB appears on `dout` at the next falling edge, with one bit per falling edge after that. `dout` is 0 before the result, after the result and while idle.
- R6: Mode field 2'b11 delays the strobe and the MSB by LONG_EXTRA falling edges (default 8). The strobe then rises at falling edge 15, the MSB appears at edge 16, and the frame lasts 32 clocks.
- R7: `user_out` takes control bits 2:0 at the 8th rising edge of the byte, and at no other time.
- R8: After a frame ends the block is armed again without any chip-select toggle. Ones on the data input during a running frame have no effect unless a re-arm has occurred.
- R9: If `cs_n` goes high and then low during a frame, the frame continues. A start bit seen after that aborts it: `sstrb` and `dout` clear, and a fresh frame begins with the new control byte.
- R10: While `shdn` is high, serial-clock edges are ignored and `user_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; also clears the user outputs |
| sclk | input | 1 | Serial clock, sampled on `clk` |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data input |
| shdn | input | 1 | Shutdown; freezes the block and the user outputs |
| result_i | input | RES_W | Parallel conversion result, sampled at the strobe edge |
| sstrb | output | 1 | Strobe pulse before the result |
| dout | output | 1 | Serial result output |
| user_out | output | 3 | User-programmable output bits |

## Verification
`sstrb` and `dout` change on the first `clk` edge after a serial-clock fall is seen. That is one register stage, so each value is settled within one system clock of the fall. The bench pushes the expected strobe and data value for each falling edge into a queue just before it drives that edge. A monitor pops the entry two system clocks after the fall, well inside the low phase and before the next rising edge. `user_out` is loaded at the 8th rising edge, so it is compared only after a whole frame, or after a whole shutdown sequence, has been clocked.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
   localparam int CTL_W        = 8;       // control byte length
   localparam int USR_W        = 3;       // user output bits, control bits 2:0
   localparam int BIT_MODE_LO  = 3;       // mode field occupies bits 4:3
   localparam int STRB_FALL    = 7;       // short-mode strobe falling edge
   localparam logic [1:0] MODE_LONG = 2'b11;
endpackage

// File: rtl/sadc_edge_det.sv
module sadc_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic en_i,
   output logic rise_o,
   output logic fall_o
);
   logic sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_i;
   end

   assign rise_o = en_i &  sclk_i & ~sclk_q;
   assign fall_o = en_i & ~sclk_i &  sclk_q;
endmodule

// File: rtl/sadc_arm.sv
module sadc_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic rise_i,
   input  logic din_i,
   input  logic done_i,
   output logic start_o,
   output logic active_o
);
   logic active_q;
   logic rearm_q;

   // a 1 starts a frame when idle, or when a chip-select toggle re-armed us
   assign start_o  = rise_i & din_i & (~active_q | rearm_q);
   assign active_o = active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rearm_q  <= 1'b0;
      end else if (start_o) begin
         active_q <= 1'b1;
         rearm_q  <= 1'b0;
      end else if (done_i) begin
         active_q <= 1'b0;
         rearm_q  <= 1'b0;
      end else if (active_q && cs_n_i) begin
         rearm_q  <= 1'b1;
      end
   end

   AST_ARMED_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> !active_q);                                              // R8
endmodule

// File: rtl/sadc_ctl_cap.sv
module sadc_ctl_cap
   import sadc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             rise_i,
   input  logic             din_i,
   output logic [1:0]       mode_o,
   output logic [USR_W-1:0] user_o
);
   localparam int CNT_W   = $clog2(CTL_W + 1);
   localparam int MODE_AT = CTL_W - 1 - BIT_MODE_LO;   // count when the low mode bit arrives
   localparam int USER_AT = CTL_W - 1;                 // count when the last bit arrives

   logic [CNT_W-1:0] rcnt_q;
   logic [USR_W-2:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt_q <= '0;
         hist_q <= '0;
         mode_o <= '0;
         user_o <= '0;
      end else if (start_i) begin
         rcnt_q <= CNT_W'(1);
         hist_q <= '0;
         mode_o <= '0;
      end else if (rise_i && rcnt_q != '0 && rcnt_q < CNT_W'(CTL_W)) begin
         rcnt_q <= rcnt_q + 1'b1;
         hist_q <= {hist_q[USR_W-3:0], din_i};
         if (rcnt_q == CNT_W'(MODE_AT)) mode_o <= {hist_q[0], din_i};
         if (rcnt_q == CNT_W'(USER_AT)) user_o <= {hist_q, din_i};
      end
   end

   AST_USER_AT_BYTE_END: assert property (@(posedge clk) disable iff (!rst_n)
      (user_o != $past(user_o)) |-> ($past(rcnt_q) == CNT_W'(USER_AT)));  // R7
endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq
   import sadc_pkg::*;
#(
   parameter int RES_W      = 14,
   parameter int LONG_EXTRA = 8,
   parameter int TAIL_CLKS  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             active_i,
   input  logic             fall_i,
   input  logic             long_i,
   input  logic [RES_W-1:0] result_i,
   output logic             sstrb_o,
   output logic             dout_o,
   output logic             done_o
);
   localparam int STRB_S  = STRB_FALL;
   localparam int STRB_L  = STRB_FALL + LONG_EXTRA;
   localparam int FRAME_S = STRB_S + RES_W + TAIL_CLKS;
   localparam int FRAME_L = FRAME_S + LONG_EXTRA;
   localparam int CNT_W   = $clog2(FRAME_L + 1);

   if (RES_W < 2 || TAIL_CLKS < 1 || LONG_EXTRA < 0) begin : g_bad_param
      $error("sadc_frame_seq: illegal RES_W, TAIL_CLKS or LONG_EXTRA");
   end

   logic [CNT_W-1:0] fcnt_q;
   logic [CNT_W-1:0] fcnt_nxt;
   logic [CNT_W-1:0] strb_pt;
   logic [CNT_W-1:0] frame_pt;
   logic [RES_W-1:0] shreg_q;

   if (LONG_EXTRA > 0) begin : g_long
      assign strb_pt  = long_i ? CNT_W'(STRB_L)  : CNT_W'(STRB_S);
      assign frame_pt = long_i ? CNT_W'(FRAME_L) : CNT_W'(FRAME_S);
   end else begin : g_short_only
      logic unused_long;
      assign unused_long = long_i;
      assign strb_pt     = CNT_W'(STRB_S);
      assign frame_pt    = CNT_W'(FRAME_S);
   end

   assign fcnt_nxt = fcnt_q + 1'b1;
   assign done_o   = active_i & fall_i & (fcnt_nxt == frame_pt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt_q  <= '0;
         sstrb_o <= 1'b0;
         dout_o  <= 1'b0;
         shreg_q <= '0;
      end else if (start_i) begin
         fcnt_q  <= '0;
         sstrb_o <= 1'b0;
         dout_o  <= 1'b0;
         shreg_q <= '0;
      end else if (active_i && fall_i) begin
         fcnt_q  <= fcnt_nxt;
         sstrb_o <= (fcnt_nxt == strb_pt);
         if (fcnt_nxt == strb_pt) begin
            shreg_q <= result_i;
            dout_o  <= 1'b0;
         end else begin
            shreg_q <= {shreg_q[RES_W-2:0], 1'b0};
            dout_o  <= done_o ? 1'b0 : shreg_q[RES_W-1];
         end
      end
   end

   AST_STRB_AT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sstrb_o) |-> (fcnt_q == strb_pt));                            // R4
   AST_STRB_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (sstrb_o && fall_i && active_i) |=> !sstrb_o);                      // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |-> (!dout_o && !sstrb_o));                               // R5
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!sstrb_o && !dout_o));                                 // R9
endmodule

// File: rtl/sadc_ctrl_if.sv
module sadc_ctrl_if
   import sadc_pkg::*;
#(
   parameter int RES_W      = 14,
   parameter int LONG_EXTRA = 8,
   parameter int TAIL_CLKS  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk,
   input  logic             cs_n,
   input  logic             din,
   input  logic             shdn,
   input  logic [RES_W-1:0] result_i,
   output logic             sstrb,
   output logic             dout,
   output logic [USR_W-1:0] user_out
);
   logic       rise;
   logic       fall;
   logic       start;
   logic       active;
   logic       done;
   logic [1:0] mode;

   sadc_edge_det u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_i (sclk),
      .en_i   (~cs_n & ~shdn),
      .rise_o (rise),
      .fall_o (fall)
   );

   sadc_arm u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_i   (cs_n),
      .rise_i   (rise),
      .din_i    (din),
      .done_i   (done),
      .start_o  (start),
      .active_o (active)
   );

   sadc_ctl_cap u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .rise_i  (rise),
      .din_i   (din),
      .mode_o  (mode),
      .user_o  (user_out)
   );

   sadc_frame_seq #(
      .RES_W      (RES_W),
      .LONG_EXTRA (LONG_EXTRA),
      .TAIL_CLKS  (TAIL_CLKS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .active_i (active),
      .fall_i   (fall),
      .long_i   (mode == MODE_LONG),
      .result_i (result_i),
      .sstrb_o  (sstrb),
      .dout_o   (dout),
      .done_o   (done)
   );

   AST_SHDN_HOLDS_USER: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn && $past(shdn)) |-> $stable(user_out));                       // R10
   AST_NO_EDGE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !start);                                                   // R2
endmodule

// File: tb/sadc_ctrl_if_bench.sv
module sadc_ctrl_if_bench;
   typedef struct {
      logic  es;
      logic  ed;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b1;
   logic        din = 1'b0;
   logic        shdn = 1'b0;
   logic [13:0] result_i = '0;
   logic        sstrb;
   logic        dout;
   logic [2:0]  user_out;

   int   n_run  = 0;
   int   n_fail = 0;
   bit   ended  = 1'b0;
   exp_t q[$];

   always #2 clk = ~clk;

   sadc_ctrl_if u_sadc_ctrl_if (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
      .shdn(shdn), .result_i(result_i), .sstrb(sstrb), .dout(dout),
      .user_out(user_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one serial clock; expectation for its falling edge is queued first
   task automatic clk_bit(input logic d, input logic es, input logic ed, input string tag);
      exp_t e;
      din = d;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      e.es = es; e.ed = ed; e.tag = tag;
      q.push_back(e);
      sclk = 1'b0;
   endtask

   // clocks first..last of a frame for control byte c and result r
   task automatic run_frame(input logic [7:0] c, input logic [13:0] r, input int first,
                            input int last, input logic dafter, input string tag);
      int s;
      s = (c[4:3] == 2'b11) ? 15 : 7;
      for (int n = first; n <= last; n++) begin
         logic d, es, ed;
         d  = (n <= 8) ? c[8-n] : dafter;
         es = (n == s);
         ed = (n > s && n <= s + 14) ? r[13-(n-s-1)] : 1'b0;
         clk_bit(d, es, ed, tag);
      end
   endtask

   // monitor: scoreboard pop two system clocks after each serial fall
   initial begin
      forever begin
         @(negedge sclk);
         repeat (2) @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (sstrb !== e.es || dout !== e.ed) begin
               n_fail++;
               $display("FAIL %s sstrb=%b dout=%b expected sstrb=%b dout=%b",
                        e.tag, sstrb, dout, e.es, e.ed);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_fail++;
         n_run++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 sstrb in reset", int'(sstrb), 0);
      chk("R1 dout in reset", int'(dout), 0);
      chk("R1 user_out in reset", int'(user_out), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 user_out after release", int'(user_out), 0);

      // R2: ones with chip-select high start nothing
      for (int i = 0; i < 6; i++) clk_bit(1'b1, 1'b0, 1'b0, "R2 cs high");
      cs_n = 1'b0;
      // R3: leading zeros are ignored
      for (int i = 0; i < 4; i++) clk_bit(1'b0, 1'b0, 1'b0, "R3 leading zeros");

      // R4/R5 short frame; R8 ones during the frame are ignored
      result_i = 14'h2A5C;
      run_frame(8'b1000_0101, 14'h2A5C, 1, 24, 1'b1, "R4 R5 R8 short frame");
      repeat (4) @(negedge clk);
      chk("R7 user_out after short byte", int'(user_out), 3'b101);

      // R6 long frame right after, no chip-select toggle (R8 re-arm)
      result_i = 14'h1E37;
      run_frame(8'b1001_1011, 14'h1E37, 1, 32, 1'b0, "R6 R8 long frame");
      repeat (4) @(negedge clk);
      chk("R7 user_out after long byte", int'(user_out), 3'b011);

      // R9: abort a frame by toggling chip-select and sending a new start bit
      result_i = 14'h3001;
      run_frame(8'b1000_0110, 14'h3001, 1, 12, 1'b0, "R9 frame before abort");
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      cs_n = 1'b0;
      repeat (2) @(negedge clk);
      run_frame(8'b1000_0110, 14'h3001, 13, 14, 1'b0, "R9 toggle alone keeps frame");
      result_i = 14'h0ABC;
      run_frame(8'b1000_0001, 14'h0ABC, 1, 24, 1'b0, "R9 restarted frame");
      repeat (4) @(negedge clk);
      chk("R9 user_out from new byte", int'(user_out), 3'b001);

      // R10: shutdown ignores the clock and keeps user outputs
      shdn = 1'b1;
      for (int n = 1; n <= 24; n++) begin
         logic [7:0] c;
         c = 8'b1001_1110;
         clk_bit((n <= 8) ? c[8-n] : 1'b0, 1'b0, 1'b0, "R10 shutdown");
      end
      repeat (4) @(negedge clk);
      chk("R10 user_out held in shutdown", int'(user_out), 3'b001);
      shdn = 1'b0;
      repeat (2) @(negedge clk);

      // R1: reset clears the user outputs
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 user_out cleared by reset", int'(user_out), 0);
      rst_n = 1'b1;
      repeat (8) @(negedge clk);

      if (!ended) begin
         ended = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule